// File: doc/BRIEF.md
# SDRAM Refresh and Control-Command Sequencer

This block keeps the memory devices behind a two-block SDRAM controller alive and carries out the control commands that software issues. It has an interval timer that counts down from a programmable reload value. The reload value is the per-row refresh time expressed in bus clocks. For example, 15625 ns per row at a 60 MHz bus gives 937. Each time the timer expires, the block raises a refresh request towards the access engine. When the engine grants the bus, the block issues one auto-refresh to every block whose refresh is turned on. It then holds off row activation for a programmable gap of 3, 6 or 9 clocks.

Software presents single-cycle commands on a small command port. There are six commands:
- Mode-register set and precharge-all. These go to the one block that the select input picks.
- Auto-refresh on and auto-refresh off. These also act on the selected block.
- Self-refresh entry and self-refresh exit. These act on both blocks at once, and the select input is ignored.

Every command produces a one-cycle completion pulse together with a success flag. Only mode-register set and precharge-all can fail. The usual bring-up order is: a precharge-all, then auto-refresh on, then at least eight refresh cycles, then the mode-register set.

Top module: `sdram_refcmd_ctrl`

## Requirements
- R1: After reset, cke is 1; cs_n, ras_n, cas_n and we_n are all 1; refresh_req, busy and done are 0; act_allow is 1.
- R2: While at least one block has auto-refresh on and the devices are not in self-refresh, refresh_req rises reload_val+1 clocks after the edge that accepts the auto-refresh-on command. With the bus granted throughout, consecutive refreshes are exactly reload_val+1 clocks apart.
- R3: A pending refresh_req stays high until bus_grant is 1. In the cycle after a clock edge with refresh_req=1, bus_grant=1, act_allow=1 and no command presented, the pins carry a refresh command for one cycle (ras_n=0, cas_n=0, we_n=1, cke=1), and refresh_req is 0. During that refresh, cs_n is low for exactly the blocks whose refresh is on.
- R4: act_allow is 0 for exactly 3, 6 or 9 cycles, starting with the refresh cycle, for gap_sel values 0, 1 and 2. The value 3 also gives 9.
- R5: Self-refresh entry (cmd_code 2) ignores cmd_blk. In the next cycle cs_n is 00 and ras_n/cas_n/we_n are 0/0/1, and cke falls to 0. While the devices are in self-refresh, cke stays 0, cs_n stays 11, refresh_req stays 0 and act_allow stays 0.
- R6: Self-refresh exit (cmd_code 3) raises cke in the next cycle with no command on the pins. It then starts a refresh-to-activate gap of the length chosen by gap_sel.
- R7: A successful mode-register set (cmd_code 0) drives ras_n/cas_n/we_n = 0/0/0. A successful precharge-all (cmd_code 1) drives 0/1/0. In both cases cs_n is low only for the block selected by cmd_blk, for one cycle.
- R8: Mode-register set and precharge-all fail when any of these is true: the selected block is disabled in blk_enable, busy is 1, or the devices are in self-refresh. A failed command reports done_ok=0 and leaves all cs_n high.
- R9: Auto-refresh on (cmd_code 4) and off (cmd_code 5) act on the selected block only. When refresh is off for every block, no refresh is issued and refresh_req stays 0.
- R10: Every presented command gives done=1 for exactly one cycle in the next cycle. Codes 2 to 5 always give done_ok=1. Codes 6 and 7 give done_ok=0 and have no effect.
- R11: busy is 1 while a refresh request is pending or a refresh-to-activate gap is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reload_val | input | 16 | Refresh interval in bus clocks, minus one |
| gap_sel | input | 2 | Refresh-to-activate gap: 0=3, 1=6, 2 or 3=9 clocks |
| blk_enable | input | 2 | Per-block enable, one bit per block |
| bus_grant | input | 1 | Access engine yields the memory pins for a refresh |
| cmd_valid | input | 1 | Command presented this cycle |
| cmd_code | input | 3 | 0 MRS, 1 precharge-all, 2 SR enter, 3 SR exit, 4 AR on, 5 AR off |
| cmd_blk | input | 1 | Target block of the command |
| refresh_req | output | 1 | Refresh pending, waiting for a grant |
| act_allow | output | 1 | Row activation permitted |
| busy | output | 1 | Refresh pending or gap running |
| done | output | 1 | Command completed (one-cycle pulse) |
| done_ok | output | 1 | Command succeeded, valid with done |
| cke | output | 1 | Clock enable to the devices |
| cs_n | output | 2 | Chip select per block, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
Some properties are checked on every cycle by assertions:
- A refresh on the pins is always preceded by a pending request and a grant.
- A mode-register set or precharge-all selects exactly one block.
- A failed command leaves the pins idle.
- Nothing is issued while cke is held low.
- The interval and gap counters only move down by one.

Other behaviour can only be shown by the bench's scenarios:
- The exact interval between refreshes.
- The exact length of each gap setting.
- The bring-up order leading to a successful mode-register set.
- That the block select is ignored on self-refresh entry.
- That refreshes stop once every block has turned refresh off.

// File: rtl/sdram_refcmd_pkg.sv
// Shared command codes and pin encodings for the refresh/command sequencer.
package sdram_refcmd_pkg;

    typedef enum logic [2:0] {
        CMD_MRS      = 3'd0,
        CMD_PREALL   = 3'd1,
        CMD_SR_ENTER = 3'd2,
        CMD_SR_EXIT  = 3'd3,
        CMD_AR_ON    = 3'd4,
        CMD_AR_OFF   = 3'd5
    } ctl_cmd_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_cmd_t;

    localparam pin_cmd_t PIN_NOP = 3'b111;
    localparam pin_cmd_t PIN_REF = 3'b001;
    localparam pin_cmd_t PIN_PRE = 3'b010;
    localparam pin_cmd_t PIN_MRS = 3'b000;

endpackage

// File: rtl/rfc_interval_timer.sv
// Refresh interval down-counter.
// The counter reloads from reload_val while it is stopped, and also each
// time it reaches zero. It pulses expire in the cycle where it sits at zero
// while running, so the period is reload_val+1 clocks.
// Assumes reload_val is held stable while run is high.
module rfc_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    assign expire = run && (cnt == '0);

    // Count down while running; reload when stopped or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || cnt == '0)
            cnt <= reload_val;
        else
            cnt <= cnt - CNT_W'(1);
    end

    a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    a_r2_reload_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt == $past(reload_val)));

endmodule

// File: rtl/rfc_gap_timer.sv
// Refresh-to-activate gap counter.
// On load, the counter takes a length of GAP_STEP times 1, 2 or 3, chosen
// by sel. The value 3 for sel gives the longest gap. idle is high once the
// counter has run down to zero.
module rfc_gap_timer #(
    parameter int GAP_STEP = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] sel,
    output logic       idle
);
    localparam int MAX_GAP = 3 * GAP_STEP;
    localparam int GAP_W   = $clog2(MAX_GAP + 1);

    logic [GAP_W-1:0] cnt;

    // Map the select code to a gap length in clocks.
    function automatic logic [GAP_W-1:0] gap_len(input logic [1:0] s);
        case (s)
            2'd0:    return GAP_W'(GAP_STEP);
            2'd1:    return GAP_W'(2 * GAP_STEP);
            default: return GAP_W'(MAX_GAP);
        endcase
    endfunction

    assign idle = (cnt == '0);

    // Load the chosen gap, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= gap_len(sel);
        else if (cnt != '0)
            cnt <= cnt - GAP_W'(1);
    end

    a_r4_gap_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - GAP_W'(1)));

    a_r4_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= GAP_W'(MAX_GAP));

endmodule

// File: rtl/rfc_sequencer.sv
// Command and refresh sequencer.
// Holds per-block auto-refresh flags, the self-refresh state and the
// pending-refresh flag. It arbitrates a granted refresh against software
// commands and drives registered SDRAM pins.
// Assumes: a presented command wins the cycle, and a refresh then waits
// one more cycle. Mode-register set and precharge-all are refused while
// busy, which keeps them from ever colliding with a refresh.
module rfc_sequencer
    import sdram_refcmd_pkg::*;
#(
    parameter int NUM_BLK = 2,
    parameter int BLK_W   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_code,
    input  logic [BLK_W-1:0]   cmd_blk,
    input  logic [NUM_BLK-1:0] blk_enable,
    input  logic               bus_grant,
    input  logic               expire,
    input  logic               gap_idle,
    output logic               run,
    output logic               gap_load,
    output logic               refresh_req,
    output logic               act_allow,
    output logic               busy,
    output logic               done,
    output logic               done_ok,
    output logic               cke,
    output logic [NUM_BLK-1:0] cs_n,
    output logic               ras_n,
    output logic               cas_n,
    output logic               we_n
);
    logic [NUM_BLK-1:0] ar_en;
    logic [NUM_BLK-1:0] sel_oh;
    logic               in_sr;
    pin_cmd_t           pin_q;
    logic               fire, access_ok, cmd_ok, sr_enter_go, sr_exit_go;
    ctl_cmd_e           code;

    // One-hot decode of the target block.
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_sel
        assign sel_oh[g] = (cmd_blk == BLK_W'(g));
    end

    assign code      = ctl_cmd_e'(cmd_code);
    assign run       = (|ar_en) && !in_sr;
    assign busy      = refresh_req || !gap_idle;
    assign act_allow = gap_idle && !in_sr;
    assign ras_n     = pin_q.ras_n;
    assign cas_n     = pin_q.cas_n;
    assign we_n      = pin_q.we_n;
    assign gap_load  = fire || sr_exit_go;

    // Decide what may issue this cycle and whether a command succeeds.
    always_comb begin
        access_ok   = (|(blk_enable & sel_oh)) && !busy && !in_sr;
        fire        = refresh_req && bus_grant && gap_idle && run && !cmd_valid;
        sr_enter_go = cmd_valid && (code == CMD_SR_ENTER) && !in_sr;
        sr_exit_go  = cmd_valid && (code == CMD_SR_EXIT) && in_sr;
        case (code)
            CMD_MRS, CMD_PREALL:                            cmd_ok = access_ok;
            CMD_SR_ENTER, CMD_SR_EXIT, CMD_AR_ON, CMD_AR_OFF: cmd_ok = 1'b1;
            default:                                        cmd_ok = 1'b0;
        endcase
    end

    // Register pins, completion and sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q       <= PIN_NOP;
            cs_n        <= '1;
            cke         <= 1'b1;
            in_sr       <= 1'b0;
            ar_en       <= '0;
            refresh_req <= 1'b0;
            done        <= 1'b0;
            done_ok     <= 1'b0;
        end else begin
            pin_q       <= PIN_NOP;
            cs_n        <= '1;
            done        <= cmd_valid;
            done_ok     <= cmd_valid && cmd_ok;
            refresh_req <= expire || (refresh_req && !fire && !sr_enter_go && run);
            if (fire) begin
                pin_q <= PIN_REF;
                cs_n  <= ~ar_en;
            end
            if (cmd_valid) begin
                case (code)
                    CMD_MRS: if (access_ok) begin
                        pin_q <= PIN_MRS;
                        cs_n  <= ~sel_oh;
                    end
                    CMD_PREALL: if (access_ok) begin
                        pin_q <= PIN_PRE;
                        cs_n  <= ~sel_oh;
                    end
                    CMD_SR_ENTER: if (!in_sr) begin
                        pin_q <= PIN_REF;
                        cs_n  <= '0;
                        cke   <= 1'b0;
                        in_sr <= 1'b1;
                    end
                    CMD_SR_EXIT: if (in_sr) begin
                        cke   <= 1'b1;
                        in_sr <= 1'b0;
                    end
                    CMD_AR_ON:  ar_en[cmd_blk] <= 1'b1;
                    CMD_AR_OFF: ar_en[cmd_blk] <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    a_r3_ref_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !ras_n && !cas_n && we_n) |-> ($past(bus_grant) && $past(refresh_req)));

    a_r5_quiet_in_self_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> (&cs_n));

    a_r7_single_block: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !ras_n && !we_n) |-> ($countones(~cs_n) == 1));

    a_r8_fail_leaves_pins_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ok) |-> (&cs_n));

    a_r10_done_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cmd_valid));

endmodule

// File: rtl/sdram_refcmd_ctrl.sv
// Top of the SDRAM refresh and control-command sequencer.
// Ties the interval timer, the gap timer and the sequencer together.
// Assumes the access engine keeps bus_grant high only while it leaves the
// memory pins idle.
module sdram_refcmd_ctrl #(
    parameter int NUM_BLK  = 2,
    parameter int CNT_W    = 16,
    parameter int GAP_STEP = 3,
    localparam int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   reload_val,
    input  logic [1:0]         gap_sel,
    input  logic [NUM_BLK-1:0] blk_enable,
    input  logic               bus_grant,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_code,
    input  logic [BLK_W-1:0]   cmd_blk,
    output logic               refresh_req,
    output logic               act_allow,
    output logic               busy,
    output logic               done,
    output logic               done_ok,
    output logic               cke,
    output logic [NUM_BLK-1:0] cs_n,
    output logic               ras_n,
    output logic               cas_n,
    output logic               we_n
);
    logic run, expire, gap_load, gap_idle;

    rfc_interval_timer #(.CNT_W(CNT_W)) u_interval (
        .clk(clk), .rst_n(rst_n), .run(run),
        .reload_val(reload_val), .expire(expire)
    );

    rfc_gap_timer #(.GAP_STEP(GAP_STEP)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load),
        .sel(gap_sel), .idle(gap_idle)
    );

    rfc_sequencer #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_blk(cmd_blk),
        .blk_enable(blk_enable), .bus_grant(bus_grant),
        .expire(expire), .gap_idle(gap_idle),
        .run(run), .gap_load(gap_load),
        .refresh_req(refresh_req), .act_allow(act_allow), .busy(busy),
        .done(done), .done_ok(done_ok), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

endmodule

// File: tb/sdram_refcmd_ctrl_test.sv
// Scoreboard bench. The send task queues the expected completion vector
// {done_ok, cke, cs_n, ras_n, cas_n, we_n}. The monitor pops an entry on
// every done pulse and compares it with the design's outputs.
module sdram_refcmd_ctrl_test;
    localparam int RLD = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [15:0] reload_val;
    logic [1:0] gap_sel;
    logic [1:0] blk_enable;
    logic       bus_grant, cmd_valid;
    logic [2:0] cmd_code;
    logic [0:0] cmd_blk;
    logic       refresh_req, act_allow, busy, done, done_ok, cke;
    logic [1:0] cs_n;
    logic       ras_n, cas_n, we_n;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [6:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    sdram_refcmd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reload_val(reload_val), .gap_sel(gap_sel),
        .blk_enable(blk_enable), .bus_grant(bus_grant), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_blk(cmd_blk), .refresh_req(refresh_req),
        .act_allow(act_allow), .busy(busy), .done(done), .done_ok(done_ok),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit ref_seen();
        return cke && !ras_n && !cas_n && we_n && (cs_n != 2'b11);
    endfunction

    // Monitor: compare every completion against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0)
                check("R10", 32'd1, 32'd0, "done without a queued command");
            else
                check(tag_q.pop_front(),
                      {25'd0, done_ok, cke, cs_n, ras_n, cas_n, we_n},
                      {25'd0, exp_q.pop_front()}, "completion vector");
        end
    end

    // Watchdog and cycle count.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 50000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic send(input logic [2:0] code, input logic blk,
                        input logic [6:0] exp, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        cmd_blk   = blk;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R10", {31'd0, done}, 32'd1, "done pulse");
    endtask

    task automatic wait_ref();
        do @(negedge clk); while (!ref_seen());
    endtask

    task automatic wait_act();
        while (!act_allow) @(negedge clk);
    endtask

    // Called at the sample point of the refresh or exit cycle.
    task automatic check_gap(input int n, input string tag);
        int low = 0;
        for (int i = 0; i < n; i++) begin
            if (!act_allow && busy) low++;
            @(negedge clk);
        end
        check(tag, low, n, "cycles with act_allow low and busy high");
        check(tag, {31'd0, act_allow}, 32'd1, "act_allow after gap");
    endtask

    initial begin
        int t0;
        int bad;
        rst_n = 1'b0; reload_val = 16'(RLD); gap_sel = 2'd0; blk_enable = 2'b01;
        bus_grant = 1'b0; cmd_valid = 1'b0; cmd_code = 3'd0; cmd_blk = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {26'd0, cke, cs_n, ras_n, cas_n, we_n}, {26'd0, 6'b111111}, "pins");
        check("R1", {29'd0, refresh_req, busy, done}, 32'd0, "req/busy/done");
        check("R1", {31'd0, act_allow}, 32'd1, "act_allow");

        send(3'd1, 1'b0, 7'b1_1_10_010, "R7 precharge blk0");
        send(3'd1, 1'b1, 7'b0_1_11_111, "R8 precharge disabled blk1");
        send(3'd6, 1'b0, 7'b0_1_11_111, "R10 unused code");

        // R2: the first request arrives RLD+1 edges after acceptance
        send(3'd4, 1'b0, 7'b1_1_11_111, "R9 auto-refresh on blk0");
        repeat (RLD) @(negedge clk);
        check("R2", {31'd0, refresh_req}, 32'd0, "req one cycle early");
        @(negedge clk);
        check("R2", {31'd0, refresh_req}, 32'd1, "req on time");
        check("R11", {31'd0, busy}, 32'd1, "busy with pending refresh");

        send(3'd0, 1'b0, 7'b0_1_11_111, "R8 MRS while busy");
        bad = 0;
        repeat (4) begin
            @(negedge clk);
            if (!refresh_req || ref_seen()) bad++;
        end
        check("R3", bad, 0, "request held without grant");

        bus_grant = 1'b1;
        @(negedge clk);
        check("R3", {31'd0, ref_seen()}, 32'd1, "refresh after grant");
        check("R3", {30'd0, cs_n}, 32'b10, "refresh on blk0 only");
        check("R3", {31'd0, refresh_req}, 32'd0, "req cleared");
        check_gap(3, "R4 gap sel0");

        wait_ref();
        t0 = cyc;
        wait_ref();
        check("R2", cyc - t0, RLD + 1, "refresh spacing");
        repeat (5) wait_ref();   // eight refreshes in total
        wait_act();
        send(3'd0, 1'b0, 7'b1_1_10_000, "R7 MRS blk0 after bring-up");

        gap_sel = 2'd2; wait_ref(); check_gap(9, "R4 gap sel2");
        gap_sel = 2'd3; wait_ref(); check_gap(9, "R4 gap sel3");
        gap_sel = 2'd1; wait_ref(); check_gap(6, "R4 gap sel1");

        // R5: entry with select 1 still covers both blocks
        send(3'd2, 1'b1, 7'b1_0_00_001, "R5 self-refresh enter");
        bad = 0;
        repeat (3 * (RLD + 1)) begin
            @(negedge clk);
            if (cke || cs_n != 2'b11 || refresh_req || act_allow) bad++;
        end
        check("R5", bad, 0, "cycles not quiet in self-refresh");
        send(3'd0, 1'b0, 7'b0_0_11_111, "R8 MRS in self-refresh");

        send(3'd3, 1'b1, 7'b1_1_11_111, "R6 self-refresh exit");
        check_gap(6, "R6 gap after exit");

        blk_enable = 2'b11;
        send(3'd4, 1'b1, 7'b1_1_11_111, "R9 auto-refresh on blk1");
        wait_ref();
        check("R9", {30'd0, cs_n}, 32'b00, "refresh on both blocks");
        wait_act();
        send(3'd1, 1'b1, 7'b1_1_01_010, "R7 precharge blk1");

        send(3'd5, 1'b0, 7'b1_1_11_111, "R9 auto-refresh off blk0");
        wait_ref();
        check("R9", {30'd0, cs_n}, 32'b01, "refresh on blk1 only");
        wait_act();
        send(3'd5, 1'b1, 7'b1_1_11_111, "R9 auto-refresh off blk1");
        @(negedge clk);
        bad = 0;
        repeat (2 * (RLD + 1)) begin
            @(negedge clk);
            if (ref_seen() || refresh_req) bad++;
        end
        check("R9", bad, 0, "refresh activity with all off");

        repeat (2) @(negedge clk);
        check("R10", exp_q.size(), 0, "unmatched commands");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule